// File: doc/BRIEF.md
# Eight-Channel Input Serializer with CRC Status

The block samples eight digital field inputs, passes each through a counter filter whose hold time is chosen by two select pins, and shifts the filtered byte out over a four-wire serial port. The serial clock and chip select are treated as ordinary signals and sampled by the system clock. A falling chip select captures a frame, and every rising serial clock edge moves it on by one bit, most significant bit first.

With the narrow-frame pin low, a frame is sixteen bits long: the input byte followed by a status byte. The status byte holds a five-bit CRC of the input byte, an active-low undervoltage alarm, an active-high overtemperature flag and an active-low undervoltage warning. With the narrow-frame pin high, only the input byte is sent. Bits arriving on the serial input follow the local frame out, so several instances can be chained with the serial output of one feeding the serial input of the next. A registered fault output is high while the overtemperature or undervoltage alarm condition is present.

Top module: `din_serializer`

## Requirements
- R1: After reset `sdo` and `fault` are 0, and the filtered input byte is 0 until a filter setting lets a new value through.
- R2: With `narrow`=0, a chip-select fall captures a 16-bit word that leaves MSB first: bits 15:8 are the filtered input byte, bits 7:0 the status byte. The first bit is on `sdo` one clock after the clock edge that sees `cs_n` low, and each later bit appears one clock after the clock edge that sees a rising `sclk` while `cs_n` is low.
- R3: With `narrow`=1, only the 8-bit input byte is sent, MSB first.
- R4: Status bits 7:3 are the CRC of the input byte with generator x^5+x^4+x^2+1, processed MSB first from an all-zero start.
- R5: Status bit 2 copies `uv_alarm_n`, bit 1 copies `ot_in`, bit 0 copies `uv_warn_n`, all sampled at the capture edge.
- R6: Bits on `sdi` enter at the rising `sclk` edges and come out on `sdo` in the same order, right after the local frame (after 16 or 8 bits).
- R7: `deb_sel`=00 applies no filtering: the filtered byte takes the value of `pin_raw` at the next clock edge.
- R8: With `deb_sel` = 01, 10 or 11, a filtered bit takes a new value only after `pin_raw` has held it for T_SHORT, T_MED or T_LONG consecutive clock edges. A shorter pulse is ignored.
- R9: `fault` is 1 one clock after `ot_in`=1 or `uv_alarm_n`=0 is seen, and 0 one clock after neither is seen. `uv_warn_n` has no effect on it.
- R10: `sdo` is 0 whenever `cs_n` is high.
- R11: Changes on `pin_raw`, `ot_in`, `uv_alarm_n` or `uv_warn_n` after the capture edge do not alter the frame being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 8 | Field inputs, synchronous to `clk` |
| deb_sel | input | 2 | Filter setting: 00 none, 01 short, 10 medium, 11 long |
| narrow | input | 1 | 1 = 8-bit frame, 0 = 16-bit frame with status |
| ot_in | input | 1 | Overtemperature condition, active high |
| uv_alarm_n | input | 1 | Undervoltage alarm, active low |
| uv_warn_n | input | 1 | Undervoltage warning, active low |
| cs_n | input | 1 | Chip select, active low; its fall captures a frame |
| sclk | input | 1 | Serial clock; a rising edge advances the frame |
| sdi | input | 1 | Serial input from the upstream device in a chain |
| sdo | output | 1 | Serial output |
| fault | output | 1 | Registered fault indication |

## Verification
Every one of the 256 input bytes is read in both frame lengths. The status inputs follow the low bits of the byte, and the upstream byte is the complement of the input byte. This separates CRC errors, swapped or inverted status bits, a wrong tap for the frame length, and chained bits that arrive early, late or reversed. The filter is tried with pulses one edge shorter than the limit and exactly as long as the limit at each of the three settings, which shows where the counter is off by one. The unfiltered setting is read both in the same cycle as an input change and one cycle later, to pin down its latency. Changing every input right after capture shows whether the frame was captured once or is still tracking its sources.

// File: rtl/din_ser_pkg.sv
package din_ser_pkg;

    localparam int unsigned IN_W    = 8;
    localparam int unsigned CRC_W   = 5;
    localparam int unsigned FRAME_W = 2 * IN_W;

    // generator x^5 + x^4 + x^2 + 1 without the leading term
    localparam logic [CRC_W-1:0] CRC_GEN = 5'h15;

    typedef enum logic [1:0] {
        DEB_OFF   = 2'b00,
        DEB_SHORT = 2'b01,
        DEB_MED   = 2'b10,
        DEB_LONG  = 2'b11
    } deb_code_e;

    function automatic logic [CRC_W-1:0] crc5_of(input logic [IN_W-1:0] data);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_GEN;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/din_deb_chan.sv
module din_deb_chan #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             filt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             val;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (limit == '0) begin
            st_d.val = raw;
            st_d.cnt = '0;
        end else if (raw == st_q.val) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit - CNT_W'(1)) begin
            st_d.val = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.val;

endmodule

// File: rtl/din_frame_shift.sv
module din_frame_shift #(
    parameter int unsigned W    = 16,
    parameter int unsigned HALF = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         narrow,
    input  logic         cs_n,
    input  logic         sdi,
    input  logic [W-1:0] load_word,
    output logic         sdo
);

    typedef struct packed {
        logic [W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh = load_word;
        end else if (shift) begin
            st_d.sh = {st_q.sh[W-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (cs_n) begin
            sdo = 1'b0;
        end else if (narrow) begin
            sdo = st_q.sh[HALF-1];
        end else begin
            sdo = st_q.sh[W-1];
        end
    end

endmodule

// File: rtl/din_serializer.sv
module din_serializer
    import din_ser_pkg::*;
#(
    parameter int unsigned T_SHORT = 1250,
    parameter int unsigned T_MED   = 37500,
    parameter int unsigned T_LONG  = 150000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  pin_raw,
    input  logic [1:0]  deb_sel,
    input  logic        narrow,
    input  logic        ot_in,
    input  logic        uv_alarm_n,
    input  logic        uv_warn_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        fault
);

    localparam int unsigned CNT_W = $clog2(T_LONG + 1);

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic fault;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [CNT_W-1:0]   lim;
    logic [IN_W-1:0]    filt_w;
    logic [IN_W-1:0]    status_w;
    logic [FRAME_W-1:0] word_w;
    logic               load_w;
    logic               shift_w;

    // filter limit shared by all channels
    always_comb begin
        case (deb_code_e'(deb_sel))
            DEB_SHORT: lim = CNT_W'(T_SHORT);
            DEB_MED:   lim = CNT_W'(T_MED);
            DEB_LONG:  lim = CNT_W'(T_LONG);
            default:   lim = '0;
        endcase
    end

    for (genvar g = 0; g < IN_W; g++) begin : g_chan
        din_deb_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pin_raw[g]),
            .limit (lim),
            .filt  (filt_w[g])
        );
    end

    // edge detection and fault register
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cs_n  = cs_n;
        ctl_d.sclk  = sclk;
        ctl_d.fault = ot_in | ~uv_alarm_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{cs_n: 1'b1, sclk: 1'b0, fault: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_w   = ~cs_n & ctl_q.cs_n;
    assign shift_w  = ~cs_n & sclk & ~ctl_q.sclk;
    assign status_w = {crc5_of(filt_w), uv_alarm_n, ot_in, uv_warn_n};
    assign word_w   = narrow ? {{IN_W{1'b0}}, filt_w} : {filt_w, status_w};

    din_frame_shift #(
        .W    (FRAME_W),
        .HALF (IN_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .shift     (shift_w),
        .narrow    (narrow),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .load_word (word_w),
        .sdo       (sdo)
    );

    assign fault = ctl_q.fault;

endmodule

// File: rtl/din_serializer_chk.sv
module din_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pin_raw,
    input logic [1:0] deb_sel,
    input logic       narrow,
    input logic       ot_in,
    input logic       uv_alarm_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       fault,
    input logic [7:0] filt,
    input logic       load,
    input logic       shift
);

    AST_FILT_TO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt ^ $past(filt)) & (filt ^ $past(pin_raw))) == 8'h00); // R8

    AST_NOFILT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_sel == 2'b00) |=> (filt == $past(pin_raw))); // R7

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_in || !uv_alarm_n) |=> fault); // R9

    AST_FAULT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ot_in && uv_alarm_n) |=> !fault); // R9

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cs_n || sdo == $past(filt[7]))); // R2

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !load && !shift) |=> (cs_n || $stable(sdo) || $changed(narrow))); // R11

endmodule

bind din_serializer din_serializer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_raw    (pin_raw),
    .deb_sel    (deb_sel),
    .narrow     (narrow),
    .ot_in      (ot_in),
    .uv_alarm_n (uv_alarm_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .fault      (fault),
    .filt       (filt_w),
    .load       (load_w),
    .shift      (shift_w)
);

// File: tb/sim_din_serializer.sv
module sim_din_serializer;

    localparam int CLK_P = 10;
    localparam int LS    = 3;
    localparam int LM    = 6;
    localparam int LL    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_raw = 8'h00;
    logic [1:0] deb_sel = 2'b00;
    logic       narrow = 1'b0;
    logic       ot_in = 1'b0;
    logic       uv_alarm_n = 1'b1;
    logic       uv_warn_n = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       fault;

    int nvec  = 0;
    int nfail = 0;

    always #(CLK_P / 2) clk = ~clk;

    din_serializer #(
        .T_SHORT (LS),
        .T_MED   (LM),
        .T_LONG  (LL)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_raw    (pin_raw),
        .deb_sel    (deb_sel),
        .narrow     (narrow),
        .ot_in      (ot_in),
        .uv_alarm_n (uv_alarm_n),
        .uv_warn_n  (uv_warn_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .fault      (fault)
    );

    function automatic logic [4:0] ref_crc(input logic [7:0] d);
        logic [12:0] r;
        r = {d, 5'b00000};
        for (int i = 12; i >= 5; i--) begin
            if (r[i]) r = r ^ (13'b0000000110101 << (i - 5));
        end
        return r[4:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling clock edge; sdi carries 'up' MSB first
    task automatic read_frame(input int nbits, input logic [7:0] up, input bit mid_change,
                              output logic [31:0] got);
        got  = '0;
        cs_n = 1'b0;
        @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            got = {got[30:0], sdo};
            if (mid_change && b == 0) begin
                pin_raw    = ~pin_raw;
                ot_in      = ~ot_in;
                uv_alarm_n = ~uv_alarm_n;
                uv_warn_n  = ~uv_warn_n;
            end
            sdi  = (b < 8) ? up[7 - b] : 1'b0;
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int          lims [3];
        lims[0] = LS;
        lims[1] = LM;
        lims[2] = LL;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: outputs and filtered byte after reset
        chk("R1 sdo", {31'b0, sdo}, 32'h0);
        chk("R1 fault", {31'b0, fault}, 32'h0);
        deb_sel = 2'b11;
        pin_raw = 8'hFF;
        read_frame(16, 8'h00, 0, got);
        chk("R1 filtered byte", {24'b0, got[15:8]}, 32'h0);
        pin_raw = 8'h00;
        repeat (LL + 2) @(negedge clk);

        // R2 R4 R5 R6: full sweep, 16-bit frames
        deb_sel = 2'b00;
        narrow  = 1'b0;
        for (int v = 0; v < 256; v++) begin
            pin_raw    = v[7:0];
            ot_in      = v[0];
            uv_alarm_n = v[1];
            uv_warn_n  = v[2];
            @(negedge clk);
            read_frame(24, ~v[7:0], 0, got);
            chk("R2 data byte", {24'b0, got[23:16]}, {24'b0, v[7:0]});
            chk("R4 crc field", {27'b0, got[15:11]}, {27'b0, ref_crc(v[7:0])});
            chk("R5 status flags", {29'b0, got[10:8]}, {29'b0, v[1], v[0], v[2]});
            chk("R6 upstream byte", {24'b0, got[7:0]}, {24'b0, ~v[7:0]});
        end

        // R3 R6: full sweep, 8-bit frames
        narrow = 1'b1;
        for (int v = 0; v < 256; v++) begin
            pin_raw = v[7:0];
            @(negedge clk);
            read_frame(16, v[7:0] ^ 8'h5A, 0, got);
            chk("R3 narrow data", {24'b0, got[15:8]}, {24'b0, v[7:0]});
            chk("R6 narrow upstream", {24'b0, got[7:0]}, {24'b0, v[7:0] ^ 8'h5A});
        end
        narrow = 1'b0;

        // R9: fault for every flag combination
        for (int c = 0; c < 8; c++) begin
            ot_in      = c[0];
            uv_alarm_n = c[1];
            uv_warn_n  = c[2];
            @(negedge clk);
            chk("R9 fault", {31'b0, fault}, {31'b0, c[0] | ~c[1]});
        end
        ot_in      = 1'b0;
        uv_alarm_n = 1'b1;
        uv_warn_n  = 1'b1;

        // R7: no filter, one clock of latency
        pin_raw = 8'h00;
        @(negedge clk);
        pin_raw = 8'hA5;
        read_frame(16, 8'h00, 0, got);
        chk("R7 same-cycle capture", {24'b0, got[15:8]}, 32'h0);
        pin_raw = 8'h5A;
        @(negedge clk);
        read_frame(16, 8'h00, 0, got);
        chk("R7 next-cycle capture", {24'b0, got[15:8]}, 32'h5A);
        pin_raw = 8'h00;
        @(negedge clk);

        // R8: pulse one edge short of the limit, then exactly the limit
        for (int s = 1; s < 4; s++) begin
            deb_sel = s[1:0];
            repeat (lims[s-1] + 2) @(negedge clk);
            pin_raw = 8'hFF;
            repeat (lims[s-1] - 1) @(posedge clk);
            @(negedge clk);
            pin_raw = 8'h00;
            read_frame(16, 8'h00, 0, got);
            chk("R8 short pulse ignored", {24'b0, got[15:8]}, 32'h0);
            repeat (lims[s-1] + 2) @(negedge clk);
            pin_raw = 8'hFF;
            repeat (lims[s-1]) @(posedge clk);
            @(negedge clk);
            pin_raw = 8'h00;
            read_frame(16, 8'h00, 0, got);
            chk("R8 full pulse taken", {24'b0, got[15:8]}, 32'hFF);
            repeat (lims[s-1] + 2) @(negedge clk);
        end
        deb_sel = 2'b00;

        // R11: inputs changed after capture
        pin_raw    = 8'h3C;
        ot_in      = 1'b1;
        uv_alarm_n = 1'b0;
        uv_warn_n  = 1'b1;
        @(negedge clk);
        read_frame(24, 8'h96, 1, got);
        chk("R11 frame frozen", got[23:0], {8'h0, 8'h3C, ref_crc(8'h3C), 3'b011, 8'h96});
        pin_raw    = 8'h00;
        ot_in      = 1'b0;
        uv_alarm_n = 1'b1;
        uv_warn_n  = 1'b1;

        // R10: sdo low with chip select high, while the register holds ones
        pin_raw = 8'hFF;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R2 first bit after capture", {31'b0, sdo}, 32'h1);
        cs_n = 1'b1;
        #1;
        chk("R10 sdo idle", {31'b0, sdo}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            sclk = ~sclk;
            @(negedge clk);
            chk("R10 sdo idle with sclk", {31'b0, sdo}, 32'h0);
        end
        sclk = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule